// File: doc/BRIEF.md
# Eight-bit timer/counter with a shared prescaler

This block holds an 8-bit count that the host can load and read back. It advances on either a strobe that marks each instruction cycle (timer mode) or edges of an external input pin (counter mode). Software chooses which edge counts. One 8-bit prescaler serves either the count path or a watchdog path, never both. A 3-bit rate field picks the prescaler's division ratio. When the count wraps past its top value, a sticky flag is raised. That flag, gated by an enable input, drives the interrupt line.

The watchdog side takes a slow tick input and an enable. It issues a one-cycle timeout pulse either on every tick or, when the prescaler is assigned to it, once per prescaled group of ticks. Loading the count briefly stalls counting. When the prescaler belongs to the count path, the same load also restarts the prescaler.

Top module: `tmr8_shared_pre`

## Requirements
- R1: After reset the count is 0x00, the control register is 0x3F, and the overflow flag, the interrupt and the watchdog timeout are all low.
- R2: A pulse on `wr_cnt` loads `wr_data` into the count. A pulse on `wr_ctl` loads `wr_data[5:0]` into the control register, and the register keeps its value otherwise. Control layout: bit 5 source (0 instruction-cycle strobe, 1 external pin), bit 4 edge (0 rising, 1 falling), bit 3 prescaler assignment (0 count path, 1 watchdog), bits 2:0 rate.
- R3: In timer mode with the prescaler on the watchdog, each `icyc_tick` adds one to the count. The change shows on the third rising clock edge, counting the edge that samples the tick.
- R4: After a count load, no increment is applied during the next two instruction-cycle strobes. With the strobe held high, the loaded value holds for two edges and then resumes counting.
- R5: In counter mode the external pin is synchronized by two flops. Only the edge chosen by control bit 4 advances the count; the other edge has no effect.
- R6: With the prescaler on the count path, the count advances once per 2^(rate+1) source events. A count load restarts the prescaler from zero.
- R7: A wrap from 0xFF to 0x00 sets the overflow flag. The flag stays set through further counting until `clr_flag` is pulsed.
- R8: `irq` is high exactly when the overflow flag is set and `irq_en` is high.
- R9: With the prescaler on the watchdog and `wdg_en` high, one timeout pulse is issued per 2^rate ticks.
- R10: With the prescaler on the count path, each tick seen while `wdg_en` is high gives a one-cycle timeout one edge later. While `wdg_en` is low, ticks give no timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| icyc_tick | input | 1 | Instruction-cycle strobe |
| ext_in | input | 1 | External count input pin |
| wr_cnt | input | 1 | Load count from wr_data |
| wr_ctl | input | 1 | Load control from wr_data[5:0] |
| wr_data | input | 8 | Host write data |
| clr_flag | input | 1 | Clear the overflow flag |
| irq_en | input | 1 | Interrupt enable |
| wdg_tick | input | 1 | Watchdog tick |
| wdg_en | input | 1 | Watchdog enable |
| cnt_q | output | 8 | Count readback |
| ctl_q | output | 6 | Control readback |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |
| wdg_timeout | output | 1 | Watchdog timeout pulse |

## Verification
The hidden state is the prescaler count, the two synchronizer stages and the stall counter. Each one is checked through the count value or the timeout pulse rate. A prescaler that is not restarted, or a wrong tap choice, shows within one divide period as a wrong number of increments over a fixed window. A missing stall shows two edges after a load as a count two higher than expected. A wrong synchronizer depth moves the first increment away from the third edge. The edge select is checked by adding a lone opposite edge and requiring the count to stay where it was.

// File: rtl/tmr8_shared_pre.sv
module tmr8_shared_pre #(
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 8,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              icyc_tick,
  input  logic              ext_in,
  input  logic              wr_cnt,
  input  logic              wr_ctl,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              clr_flag,
  input  logic              irq_en,
  input  logic              wdg_tick,
  input  logic              wdg_en,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [RATE_W+2:0] ctl_q,
  output logic              ovf_flag,
  output logic              irq,
  output logic              wdg_timeout
);
  localparam int CTL_W  = RATE_W + 3;
  localparam int SRC_B  = RATE_W + 2;
  localparam int EDGE_B = RATE_W + 1;
  localparam int ASGN_B = RATE_W;

  logic [2:0]       ext_m;
  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] mask;
  logic [1:0]       sync_q;
  logic [1:0]       stall;
  logic             src_evt, wdg_evt, pre_in, pre_tc, tmr_evt, wdg_pulse, inc;
  logic             edge_hit;

  wire asgn_wdg = ctl_q[ASGN_B];
  wire [RATE_W-1:0] rate = ctl_q[RATE_W-1:0];

  assign edge_hit  = ctl_q[EDGE_B] ? (ext_m[2] & ~ext_m[1]) : (ext_m[1] & ~ext_m[2]);
  assign src_evt   = ctl_q[SRC_B] ? edge_hit : icyc_tick;
  assign wdg_evt   = wdg_tick & wdg_en;
  assign pre_in    = asgn_wdg ? wdg_evt : src_evt;
  assign mask      = asgn_wdg ? ~({PRE_W{1'b1}} << rate)
                              : ~({{(PRE_W-1){1'b1}}, 1'b0} << rate);
  assign pre_tc    = pre_in && ((pcnt & mask) == mask);
  assign tmr_evt   = asgn_wdg ? src_evt : pre_tc;
  assign wdg_pulse = asgn_wdg ? pre_tc : wdg_evt;
  assign inc       = sync_q[1] && (stall == 2'd0);
  assign irq       = ovf_flag & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_m       <= '0;
      sync_q      <= '0;
      wdg_timeout <= 1'b0;
    end else begin
      ext_m       <= {ext_m[1:0], ext_in};
      sync_q      <= {sync_q[0], tmr_evt};
      wdg_timeout <= wdg_pulse;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pcnt <= '0;
    else if (wr_cnt && !asgn_wdg) pcnt <= '0;
    else if (pre_in)            pcnt <= pcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        stall <= 2'd0;
    else if (wr_cnt)                   stall <= 2'd2;
    else if (icyc_tick && stall != 2'd0) stall <= stall - 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr_cnt) cnt_q <= wr_data;
    else if (inc)    cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    ovf_flag <= 1'b0;
    else if (inc && (&cnt_q) && !wr_cnt) ovf_flag <= 1'b1;
    else if (clr_flag)             ovf_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '1;
    else if (wr_ctl) ctl_q <= wr_data[CTL_W-1:0];
  end
endmodule

// File: rtl/tmr8_shared_pre_chk.sv
module tmr8_shared_pre_chk #(
  parameter int CNT_W  = 8,
  parameter int RATE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_cnt,
  input logic              wr_ctl,
  input logic [CNT_W-1:0]  wr_data,
  input logic              clr_flag,
  input logic              wdg_tick,
  input logic              wdg_en,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [RATE_W+2:0] ctl_q,
  input logic              ovf_flag,
  input logic              wdg_timeout
);
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(wr_data)); // R2
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctl |=> $stable(ctl_q)); // R2
  AST_LOAD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt ##1 !wr_cnt |=> $stable(cnt_q)); // R4
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '1 && !wr_cnt) |=> (cnt_q == '0 |-> ovf_flag)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_flag) |=> ovf_flag); // R7
  AST_TIMEOUT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_timeout |-> $past(wdg_en && wdg_tick)); // R10
endmodule

bind tmr8_shared_pre tmr8_shared_pre_chk #(.CNT_W(CNT_W), .RATE_W(RATE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_cnt(wr_cnt), .wr_ctl(wr_ctl), .wr_data(wr_data),
  .clr_flag(clr_flag), .wdg_tick(wdg_tick), .wdg_en(wdg_en), .cnt_q(cnt_q),
  .ctl_q(ctl_q), .ovf_flag(ovf_flag), .wdg_timeout(wdg_timeout)
);

// File: tb/tmr8_shared_pre_tb.sv
`timescale 1ns/1ps
module tmr8_shared_pre_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic icyc_tick = 1'b0, ext_in = 1'b0, wr_cnt = 1'b0, wr_ctl = 1'b0;
  logic [7:0] wr_data = '0;
  logic clr_flag = 1'b0, irq_en = 1'b0, wdg_tick = 1'b0, wdg_en = 1'b0;
  logic [7:0] cnt_q;
  logic [5:0] ctl_q;
  logic ovf_flag, irq, wdg_timeout;
  int tests = 0, fails = 0, to_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr8_shared_pre dut_i (
    .clk(clk), .rst_n(rst_n), .icyc_tick(icyc_tick), .ext_in(ext_in),
    .wr_cnt(wr_cnt), .wr_ctl(wr_ctl), .wr_data(wr_data), .clr_flag(clr_flag),
    .irq_en(irq_en), .wdg_tick(wdg_tick), .wdg_en(wdg_en), .cnt_q(cnt_q),
    .ctl_q(ctl_q), .ovf_flag(ovf_flag), .irq(irq), .wdg_timeout(wdg_timeout)
  );

  always @(negedge clk) if (wdg_timeout) to_cnt++;

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_ctl(logic [7:0] v);
    wr_data = v; wr_ctl = 1'b1; step(1); wr_ctl = 1'b0;
  endtask

  task automatic put_cnt(logic [7:0] v);
    wr_data = v; wr_cnt = 1'b1; step(1); wr_cnt = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 cnt", cnt_q, 0);
    check("R1 ctl", ctl_q, 'h3F);
    check("R1 flag", ovf_flag, 0);
    check("R1 irq", irq, 0);
    check("R1 timeout", wdg_timeout, 0);
  endtask

  task automatic t_regs;
    icyc_tick = 1'b0;
    put_ctl(8'hD5);
    check("R2 ctl", ctl_q, 'h15);
    step(3);
    check("R2 ctl hold", ctl_q, 'h15);
    put_cnt(8'hA5);
    step(4);
    check("R2 cnt", cnt_q, 'hA5);
  endtask

  task automatic t_timer;
    int a;
    put_ctl(8'h08);
    icyc_tick = 1'b1;
    put_cnt(8'h20);
    step(10);
    icyc_tick = 1'b0;
    step(5);
    a = cnt_q;
    icyc_tick = 1'b1; step(1); icyc_tick = 1'b0;
    step(1);
    check("R3 latency before", cnt_q, a);
    step(1);
    check("R3 latency third edge", cnt_q, a + 1);
    a = cnt_q;
    for (int i = 0; i < 10; i++) begin
      icyc_tick = 1'b1; step(1); icyc_tick = 1'b0; step(2);
    end
    step(5);
    check("R3 ten ticks", cnt_q, a + 10);
  endtask

  task automatic t_stall;
    put_ctl(8'h08);
    icyc_tick = 1'b1;
    step(3);
    put_cnt(8'd10);
    check("R4 load", cnt_q, 10);
    step(2);
    check("R4 stalled two", cnt_q, 10);
    step(1);
    check("R4 resumes", cnt_q, 11);
    step(7);
    check("R4 run", cnt_q, 18);
  endtask

  task automatic t_prescale;
    icyc_tick = 1'b1;
    put_ctl(8'h00); step(3); put_cnt(8'h00); step(40);
    check("R6 div2", cnt_q, 19);
    put_ctl(8'h02); step(3); put_cnt(8'h00); step(40);
    check("R6 div8", cnt_q, 4);
    put_ctl(8'h07); step(3); put_cnt(8'h00); step(600);
    check("R6 div256", cnt_q, 2);
  endtask

  task automatic pulse_ext(int n);
    for (int i = 0; i < n; i++) begin
      ext_in = 1'b1; step(4); ext_in = 1'b0; step(4);
    end
  endtask

  task automatic t_ext;
    icyc_tick = 1'b1;
    ext_in = 1'b0;
    put_ctl(8'h28); step(6); put_cnt(8'h00); step(4);
    ext_in = 1'b1; step(8);
    check("R5 rising counted", cnt_q, 1);
    ext_in = 1'b0; step(8);
    check("R5 falling ignored", cnt_q, 1);
    pulse_ext(2); step(6);
    check("R5 rising pulses", cnt_q, 3);
    put_ctl(8'h38); step(6); put_cnt(8'h00); step(4);
    pulse_ext(3); step(6);
    check("R5 falling pulses", cnt_q, 3);
    ext_in = 1'b1; step(8);
    check("R5 rising ignored", cnt_q, 3);
    ext_in = 1'b0; step(8);
    check("R5 falling counted", cnt_q, 4);
  endtask

  task automatic t_overflow;
    put_ctl(8'h08);
    icyc_tick = 1'b1;
    irq_en = 1'b1;
    step(3);
    put_cnt(8'hFE);
    step(3);
    check("R7 at top", cnt_q, 'hFF);
    check("R7 no flag yet", ovf_flag, 0);
    step(1);
    check("R7 wrapped", cnt_q, 0);
    check("R7 flag set", ovf_flag, 1);
    check("R8 irq on", irq, 1);
    irq_en = 1'b0; #1;
    check("R8 irq masked", irq, 0);
    irq_en = 1'b1;
    step(8);
    check("R7 flag sticky", ovf_flag, 1);
    icyc_tick = 1'b0;
    clr_flag = 1'b1; step(1); clr_flag = 1'b0;
    check("R7 flag cleared", ovf_flag, 0);
    check("R8 irq off", irq, 0);
  endtask

  task automatic wtick(int n);
    for (int i = 0; i < n; i++) begin
      wdg_tick = 1'b1; step(1); wdg_tick = 1'b0; step(2);
    end
  endtask

  task automatic t_wdg;
    icyc_tick = 1'b0;
    put_ctl(8'h00); put_cnt(8'h00);
    put_ctl(8'h0A);
    wdg_en = 1'b1; step(2);
    to_cnt = 0;
    wtick(16); step(3);
    check("R9 div4 pulses", to_cnt, 4);
    put_ctl(8'h00); step(2);
    wdg_tick = 1'b1; step(1); wdg_tick = 1'b0;
    check("R10 one edge later", wdg_timeout, 1);
    step(1);
    check("R10 single cycle", wdg_timeout, 0);
    to_cnt = 0;
    wtick(5); step(2);
    check("R10 per tick", to_cnt, 5);
    wdg_en = 1'b0; to_cnt = 0;
    wtick(5); step(2);
    check("R10 disabled", to_cnt, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_regs();
    t_timer();
    t_stall();
    t_prescale();
    t_ext();
    t_overflow();
    t_wdg();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule